// File: doc/BRIEF.md
# Video Clamp Pulse Generator

This block drives a single per-line reference output for a digital video decoder. It has two modes, chosen by a mode input. In indicator mode the output marks the visible part of each line: it is high during active video and low during horizontal or vertical blanking. In clamp mode the output stays high and drops for a fixed-width low pulse. The pulse starts a programmed number of pixel clocks after each horizontal sync strobe.

The pulse width is a parameter. It is the number of pixel clocks in half a microsecond, for example 14 at 27 MHz. The start offset is an 8-bit input, captured when the sync strobe is accepted. While a line's delay or pulse is still running, the sequencer ignores any further strobes. Leaving clamp mode returns the sequencer to idle at once.

Top module: `vclamp_refgen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `ref_out` is 1.
- R2: When `clamp_mode` is 0, `ref_out` is registered with one clock of latency. Its value is `active_video & ~hblank & ~vblank` as sampled at the previous rising edge.
- R3: When `clamp_mode` is 1 and no pulse is in progress, `ref_out` is 1.
- R4: In clamp mode, suppose an idle sequencer samples `hsync_stb` high at rising edge k, with `clamp_delay` equal to D (0 to 255). Then `ref_out` goes to 0 right after edge k+D.
- R5: The clamp pulse keeps `ref_out` at 0 for exactly `PULSE_CLKS` clocks. It returns to 1 after edge k+D+`PULSE_CLKS`.
- R6: A strobe sampled while a delay or pulse is in progress is ignored. This holds up to and including edge k+D+`PULSE_CLKS`.
- R7: `clamp_delay` is captured only at the accepted strobe. Changing it during a line does not move that line's pulse.
- R8: When `clamp_mode` is 0, strobes and the delay value have no effect. Dropping `clamp_mode` aborts any running delay or pulse. On return to clamp mode, `ref_out` is 1 until a new strobe is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync_stb | input | 1 | One-clock horizontal sync strobe |
| active_video | input | 1 | High during the active part of the line |
| hblank | input | 1 | Horizontal blanking interval |
| vblank | input | 1 | Vertical blanking interval |
| clamp_delay | input | DLY_W (8) | Clocks from the accepted strobe to the start of the pulse |
| clamp_mode | input | 1 | 1 = clamp pulse output, 0 = active-video indicator |
| ref_out | output | 1 | Reference output |

## Verification
The bench builds the block with `DLY_W` = 8 and `PULSE_CLKS` = 3. With so short a pulse, a whole line at the largest delay of 255 takes only a few hundred cycles. The D = 0 case, where the pulse starts on the clock right after the strobe, and the D = 255 case are both run as directed lines. The random lines then fire extra strobes right up to the last busy edge and change the delay during the line, so R6 and R7 are tested exactly at the edge where the sequencer goes back to idle.

// File: rtl/vcp_pkg.sv
package vcp_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_WAIT = 2'd1,
      SEQ_LOW  = 2'd2
   } seq_state_e;
endpackage

// File: rtl/vcp_seq.sv
module vcp_seq
   import vcp_pkg::*;
#(
   parameter int DLY_W      = 8,
   parameter int PULSE_CLKS = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             strobe,
   input  logic [DLY_W-1:0] dly,
   output seq_state_e       state_o
);
   localparam int PW_W  = (PULSE_CLKS > 1) ? $clog2(PULSE_CLKS) : 1;
   localparam int CNT_W = (DLY_W > PW_W) ? DLY_W : PW_W;
   localparam logic [CNT_W-1:0] PULSE_LOAD = CNT_W'(PULSE_CLKS - 1);

   generate
      if (PULSE_CLKS < 1) begin : g_bad_pw
         $error("PULSE_CLKS must be at least 1");
      end
      if (DLY_W < 1) begin : g_bad_dw
         $error("DLY_W must be at least 1");
      end
   endgenerate

   seq_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] dly_ext;
   logic             dly_zero;

   assign dly_ext  = CNT_W'(dly);
   assign dly_zero = (dly == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         cnt_q   <= '0;
      end else if (!enable) begin
         state_q <= SEQ_IDLE;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            SEQ_IDLE: begin
               if (strobe) begin
                  if (dly_zero) begin
                     state_q <= SEQ_LOW;
                     cnt_q   <= PULSE_LOAD;
                  end else begin
                     state_q <= SEQ_WAIT;
                     cnt_q   <= dly_ext - 1'b1;
                  end
               end
            end
            SEQ_WAIT: begin
               if (cnt_q == '0) begin
                  state_q <= SEQ_LOW;
                  cnt_q   <= PULSE_LOAD;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            SEQ_LOW: begin
               if (cnt_q == '0) begin
                  state_q <= SEQ_IDLE;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: begin
               state_q <= SEQ_IDLE;
               cnt_q   <= '0;
            end
         endcase
      end
   end

   assign state_o = state_q;
endmodule

// File: rtl/vcp_ind.sv
module vcp_ind (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic hblank,
   input  logic vblank,
   output logic ind_o
);
   logic ind_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ind_q <= 1'b1;
      else        ind_q <= active & ~hblank & ~vblank;
   end

   assign ind_o = ind_q;
endmodule

// File: rtl/vclamp_refgen.sv
module vclamp_refgen
   import vcp_pkg::*;
#(
   parameter int DLY_W      = 8,
   parameter int PULSE_CLKS = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hsync_stb,
   input  logic             active_video,
   input  logic             hblank,
   input  logic             vblank,
   input  logic [DLY_W-1:0] clamp_delay,
   input  logic             clamp_mode,
   output logic             ref_out
);
   seq_state_e seq_state;
   logic       ind_val;
   logic       in_pulse;

   vcp_seq #(.DLY_W(DLY_W), .PULSE_CLKS(PULSE_CLKS)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (clamp_mode),
      .strobe  (hsync_stb),
      .dly     (clamp_delay),
      .state_o (seq_state)
   );

   vcp_ind u_ind (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (active_video),
      .hblank (hblank),
      .vblank (vblank),
      .ind_o  (ind_val)
   );

   assign in_pulse = (seq_state == SEQ_LOW);
   assign ref_out  = clamp_mode ? ~in_pulse : ind_val;
endmodule

// File: rtl/vcp_chk.sv
module vcp_chk
   import vcp_pkg::*;
#(
   parameter int DLY_W      = 8,
   parameter int PULSE_CLKS = 14
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hsync_stb,
   input logic             active_video,
   input logic             hblank,
   input logic             vblank,
   input logic [DLY_W-1:0] clamp_delay,
   input logic             clamp_mode,
   input logic             ref_out,
   input seq_state_e       seq_state
);
   localparam int LW = $clog2(PULSE_CLKS + 2) + 1;

   logic             started_q;
   logic             arm_q;
   logic [DLY_W-1:0] exp_q;
   logic [DLY_W:0]   gap_q;
   logic [LW-1:0]    low_q;
   logic             track_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) started_q <= 1'b0;
      else        started_q <= 1'b1;
   end

   // start-offset tracker for accepted strobes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q <= 1'b0;
         exp_q <= '0;
         gap_q <= '0;
      end else if (!clamp_mode) begin
         arm_q <= 1'b0;
      end else if (seq_state == SEQ_IDLE && hsync_stb) begin
         arm_q <= 1'b1;
         exp_q <= clamp_delay;
         gap_q <= '0;
      end else if (arm_q) begin
         if (!ref_out) arm_q <= 1'b0;
         gap_q <= gap_q + 1'b1;
      end
   end

   // low-width tracker
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q   <= '0;
         track_q <= 1'b0;
      end else if (!clamp_mode) begin
         track_q <= 1'b0;
         low_q   <= '0;
      end else if (!ref_out) begin
         track_q <= 1'b1;
         if (low_q != '1) low_q <= low_q + 1'b1;
      end else begin
         track_q <= 1'b0;
         low_q   <= '0;
      end
   end

   assert_ind_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (started_q && !clamp_mode && !$past(clamp_mode))
         |-> (ref_out == $past(active_video & ~hblank & ~vblank)));

   assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (started_q && clamp_mode && $past(clamp_mode)
         && $past(seq_state) == SEQ_IDLE && !$past(hsync_stb)) |-> ref_out);

   assert_start_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_q && clamp_mode && !ref_out) |-> (gap_q == {1'b0, exp_q}));

   assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (track_q && clamp_mode && ref_out) |-> (low_q == LW'(PULSE_CLKS)));

   assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clamp_mode && seq_state == SEQ_LOW && hsync_stb) |=> (seq_state != SEQ_WAIT));

   assert_mode_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (started_q && clamp_mode && !$past(clamp_mode)) |-> ref_out);
endmodule

bind vclamp_refgen vcp_chk #(.DLY_W(DLY_W), .PULSE_CLKS(PULSE_CLKS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .hsync_stb    (hsync_stb),
   .active_video (active_video),
   .hblank       (hblank),
   .vblank       (vblank),
   .clamp_delay  (clamp_delay),
   .clamp_mode   (clamp_mode),
   .ref_out      (ref_out),
   .seq_state    (seq_state)
);

// File: tb/vclamp_refgen_tb.sv
`timescale 1ns/1ps
module vclamp_refgen_tb;
   localparam int DW = 8;
   localparam int PW = 3;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          hsync_stb;
   logic          active_video;
   logic          hblank;
   logic          vblank;
   logic [DW-1:0] clamp_delay;
   logic          clamp_mode;
   logic          ref_out;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   vclamp_refgen #(.DLY_W(DW), .PULSE_CLKS(PW)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .hsync_stb    (hsync_stb),
      .active_video (active_video),
      .hblank       (hblank),
      .vblank       (vblank),
      .clamp_delay  (clamp_delay),
      .clamp_mode   (clamp_mode),
      .ref_out      (ref_out)
   );

   function automatic bit exp_line(int i, int d);
      return !(i >= d && i < d + PW);
   endfunction

   function automatic bit exp_ind(bit a, bit hb, bit vb);
      return a & ~hb & ~vb;
   endfunction

   task automatic chk(input logic got, input bit exp, input string req);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: ref_out=%0b expected %0b at %0t", req, got, exp, $time);
      end
   endtask

   // one clamp-mode line; strobe sampled at edge k, check i is taken after edge k+i
   task automatic run_line(input int d, input bit interfere, input bit chg);
      string tag;
      @(negedge clk);
      clamp_mode  = 1'b1;
      hsync_stb   = 1'b1;
      clamp_delay = DW'(d);
      for (int i = 0; i <= d + PW + 1; i++) begin
         @(negedge clk);
         hsync_stb = 1'b0;
         if (interfere)      tag = "R6";
         else if (chg)       tag = "R7";
         else if (i < d)     tag = "R4";
         else if (i < d + PW) tag = "R5";
         else                tag = "R3";
         chk(ref_out, exp_line(i, d), tag);
         if (interfere && i <= d + PW - 1) hsync_stb = 1'($urandom_range(0, 1));
         if (chg) clamp_delay = DW'($urandom);
      end
      hsync_stb = 1'b0;
   endtask

   task automatic ind_phase(input int n);
      bit a, hb, vb;
      for (int j = 0; j < n; j++) begin
         @(negedge clk);
         clamp_mode   = 1'b0;
         a            = 1'($urandom_range(0, 1));
         hb           = ($urandom_range(0, 3) == 0);
         vb           = ($urandom_range(0, 3) == 0);
         active_video = a;
         hblank       = hb;
         vblank       = vb;
         hsync_stb    = 1'($urandom_range(0, 1));
         clamp_delay  = DW'($urandom);
         @(negedge clk);
         chk(ref_out, exp_ind(a, hb, vb), "R2");
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: ref_out=%0b expected test completion", ref_out);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'h5eed_c1a7));
      rst_n        = 1'b0;
      hsync_stb    = 1'b0;
      active_video = 1'b0;
      hblank       = 1'b1;
      vblank       = 1'b0;
      clamp_delay  = '0;
      clamp_mode   = 1'b1;
      repeat (3) @(negedge clk);
      chk(ref_out, 1'b1, "R1");
      rst_n = 1'b1;
      @(negedge clk);
      chk(ref_out, 1'b1, "R1");

      // idle clamp mode, no strobe
      for (int j = 0; j < 4; j++) begin
         @(negedge clk);
         chk(ref_out, 1'b1, "R3");
      end

      // directed corners
      run_line(0, 1'b0, 1'b0);
      run_line(1, 1'b0, 1'b0);
      run_line(255, 1'b0, 1'b0);
      run_line(0, 1'b1, 1'b0);
      run_line(5, 1'b0, 1'b1);
      run_line(2, 1'b0, 1'b0);

      // strobe landing on the edge where the sequencer returns idle is ignored
      @(negedge clk);
      hsync_stb = 1'b1; clamp_delay = 8'd2;
      for (int i = 0; i <= 2 + PW + 1; i++) begin
         @(negedge clk);
         hsync_stb = (i == 2 + PW - 1);
         chk(ref_out, exp_line(i, 2), "R6");
      end
      hsync_stb = 1'b0;

      // random lines
      for (int n = 0; n < 40; n++) begin
         run_line($urandom_range(0, 40), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end

      // indicator mode with strobes and delay churn
      ind_phase(60);

      // return to clamp mode: no pulse from strobes seen in indicator mode
      @(negedge clk);
      clamp_mode = 1'b1;
      hsync_stb  = 1'b0;
      #1 chk(ref_out, 1'b1, "R8");
      for (int j = 0; j < PW + 4; j++) begin
         @(negedge clk);
         chk(ref_out, 1'b1, "R8");
      end

      // abort a pulse by leaving clamp mode
      @(negedge clk);
      hsync_stb = 1'b1; clamp_delay = 8'd2;
      active_video = 1'b1; hblank = 1'b0; vblank = 1'b0;
      for (int i = 0; i <= 2; i++) begin
         @(negedge clk);
         hsync_stb = 1'b0;
         chk(ref_out, exp_line(i, 2), "R5");
      end
      clamp_mode = 1'b0;
      @(negedge clk);
      chk(ref_out, 1'b1, "R8");
      clamp_mode = 1'b1;
      #1 chk(ref_out, 1'b1, "R8");
      for (int j = 0; j < PW + 2; j++) begin
         @(negedge clk);
         chk(ref_out, 1'b1, "R8");
      end

      run_line(3, 1'b0, 1'b0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule